// File: doc/BRIEF.md
# Link-Down Recovery Watchdog

This block keeps a flaky serial link from staying down for good. It watches a link status input and a loopback input. While the link reports down and no loopback test is running, it counts slow interval ticks. When the interval runs out, it asks a separate reset target to perform a logic reset. That reset restarts the datapath logic but leaves the configuration registers untouched. The interval counter then starts over, so the request repeats for as long as the link stays down.

The request works like a self-clearing control bit. The watchdog raises `rst_req`, and the target reports on `rst_done` when its reset has finished. The watchdog samples `rst_done` only on fast poll ticks, and it gives up after a fixed number of polls. If it gives up, it raises a sticky timeout flag. Separately, a one-cycle pulse reports every change of the sampled link state, so a polling agent can tell that the link went up or down.

Top module: `link_recovery_wdog`

## Requirements
- R1: A synchronous active-high `rst` clears the interval count, the pending request, the poll count and the timeout flag. It also takes the previous link sample as "down". All outputs are low in the cycle after reset.
- R2: With `link_up` low, `loopback_on` low and no request pending, each cycle with `tick_ms` high advances the interval count. On the INTERVAL-th such tick, `rst_req` goes high in the following cycle.
- R3: In any cycle where `link_up` or `loopback_on` is high, the interval count returns to zero, and a `tick_ms` in that cycle is not counted.
- R4: When a request is issued, the interval count restarts from zero in the same cycle. A further request therefore needs another INTERVAL counted ticks.
- R5: `rst_req` stays high until a cycle where `tick_us` and `rst_done` are both high. It goes low in the cycle after that one. `rst_done` is ignored in cycles without `tick_us`.
- R6: If POLL_LIMIT cycles with `tick_us` high all see `rst_done` low, `rst_req` goes low in the cycle after the last of them, and `rst_timeout` goes high at the same time.
- R7: Once set, `rst_timeout` stays high until `rst`, whatever later requests do.
- R8: While a request is pending, `tick_ms` is ignored: the interval count holds and no second request is started.
- R9: `link_change` is high for the cycle after any cycle in which `link_up` differs from its value in the cycle before.
- R10: While `loopback_on` is high, no request is issued, however long the link stays down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link status, 1 = up |
| loopback_on | input | 1 | A loopback test is active |
| tick_ms | input | 1 | Single-cycle interval tick (nominally 1 kHz) |
| tick_us | input | 1 | Single-cycle poll tick (nominally 1 MHz) |
| rst_done | input | 1 | Reset target reports its logic reset finished |
| rst_req | output | 1 | Logic reset request, high while pending |
| rst_timeout | output | 1 | Sticky flag: a request was abandoned after the poll limit |
| link_change | output | 1 | One-cycle pulse on a change of link state |

## Verification
The bench goes after the edges of the interval. A counter that is off by one fires a tick early or late. A counter that keeps running during a pending request fires again straight after completion instead of after a full interval. A one-cycle link-up blip in the middle of a count must restart it; a design that only clears on a longer up period would fire early. Loopback held with the link down must never produce a request. On the poll side, `rst_done` is shown between poll ticks, where it must be ignored. An all-low poll run must give up on exactly the POLL_LIMIT-th tick and leave a timeout that survives later good resets.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

    typedef enum logic {
        POLL_IDLE = 1'b0,
        POLL_WAIT = 1'b1
    } poll_state_e;

    typedef struct packed {
        logic busy;
        logic timeout;
    } poll_status_t;

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lrw_interval_timer.sv
module lrw_interval_timer #(
    parameter int INTERVAL = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int W = lrw_pkg::cnt_bits(INTERVAL);
    localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

    logic [W-1:0] cnt;
    logic         step;

    assign step   = run && tick && !restart && !rst;
    assign expire = step && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R3
    timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R8
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt));

endmodule

// File: rtl/lrw_reset_poller.sv
module lrw_reset_poller #(
    parameter int POLL_LIMIT = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue,
    input  logic                 tick,
    input  logic                 done,
    output lrw_pkg::poll_status_t status
);
    import lrw_pkg::*;

    localparam int W = cnt_bits(POLL_LIMIT);
    localparam logic [W-1:0] LASTP = W'(POLL_LIMIT - 1);

    poll_state_e state;
    logic [W-1:0] polls;
    logic         timeout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= POLL_IDLE;
            polls     <= '0;
            timeout_q <= 1'b0;
        end else begin
            unique case (state)
                POLL_IDLE: begin
                    if (issue) begin
                        state <= POLL_WAIT;
                        polls <= '0;
                    end
                end
                POLL_WAIT: begin
                    if (tick) begin
                        if (done) begin
                            state <= POLL_IDLE;
                        end else if (polls == LASTP) begin
                            state     <= POLL_IDLE;
                            timeout_q <= 1'b1;
                        end else begin
                            polls <= polls + 1'b1;
                        end
                    end
                end
                default: state <= POLL_IDLE;
            endcase
        end
    end

    assign status.busy    = (state == POLL_WAIT);
    assign status.timeout = timeout_q;

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status.busy) |-> $past(tick));

    // R6
    timeout_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status.timeout) |-> $fell(status.busy));

    // R7
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        status.timeout |=> status.timeout);

    // R8
    no_reissue_chk: assert property (@(posedge clk) disable iff (rst)
        status.busy |-> !issue);

endmodule

// File: rtl/lrw_link_edge.sv
module lrw_link_edge (
    input  logic clk,
    input  logic rst,
    input  logic link_in,
    output logic change
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            change <= 1'b0;
        end else begin
            prev_q <= link_in;
            change <= link_in ^ prev_q;
        end
    end

endmodule

// File: rtl/link_recovery_wdog.sv
module link_recovery_wdog #(
    parameter int INTERVAL   = 5000,
    parameter int POLL_LIMIT = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic loopback_on,
    input  logic tick_ms,
    input  logic tick_us,
    input  logic rst_done,
    output logic rst_req,
    output logic rst_timeout,
    output logic link_change
);
    import lrw_pkg::*;

    poll_status_t poll_st;
    logic         hold_off;
    logic         fire;

    assign hold_off = link_up || loopback_on;

    lrw_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (hold_off),
        .run     (!poll_st.busy),
        .tick    (tick_ms),
        .expire  (fire)
    );

    lrw_reset_poller #(.POLL_LIMIT(POLL_LIMIT)) u_poller (
        .clk    (clk),
        .rst    (rst),
        .issue  (fire),
        .tick   (tick_us),
        .done   (rst_done),
        .status (poll_st)
    );

    lrw_link_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .link_in (link_up),
        .change  (link_change)
    );

    assign rst_req     = poll_st.busy;
    assign rst_timeout = poll_st.timeout;

    // R10
    loop_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(!loopback_on && !link_up && tick_ms));

    // R9
    change_source_chk: assert property (@(posedge clk) disable iff (rst)
        (link_change && !$past(rst)) |-> ($past(link_up) != $past(link_up, 2)));

endmodule

// File: tb/link_recovery_wdog_test.sv
`timescale 1ns/1ps
module link_recovery_wdog_test;
    localparam int INTERVAL   = 6;
    localparam int POLL_LIMIT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 1'b0, loopback_on = 1'b0, tick_ms = 1'b0, tick_us = 1'b0, rst_done = 1'b0;
    logic rst_req, rst_timeout, link_change;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit started = 1'b0;
    bit finished = 1'b0;

    // Reference model state
    int m_cnt = 0;
    int m_polls = 0;
    bit m_pend = 0, m_to = 0, m_chg = 0, m_prev = 0;

    always #2 clk = ~clk;

    link_recovery_wdog #(.INTERVAL(INTERVAL), .POLL_LIMIT(POLL_LIMIT)) uut (
        .clk(clk), .rst(rst), .link_up(link_up), .loopback_on(loopback_on),
        .tick_ms(tick_ms), .tick_us(tick_us), .rst_done(rst_done),
        .rst_req(rst_req), .rst_timeout(rst_timeout), .link_change(link_change)
    );

    always @(posedge clk) begin
        bit fire;
        started = 1'b1;
        fire = 1'b0;
        if (rst) begin
            m_cnt = 0; m_polls = 0; m_pend = 0; m_to = 0; m_chg = 0; m_prev = 0;
        end else begin
            m_chg  = (link_up != m_prev);
            m_prev = link_up;
            if (link_up || loopback_on) m_cnt = 0;
            else if (!m_pend && tick_ms) begin
                m_cnt++;
                if (m_cnt == INTERVAL) begin m_cnt = 0; fire = 1'b1; end
            end
            if (m_pend && tick_us) begin
                if (rst_done) m_pend = 0;
                else begin
                    m_polls++;
                    if (m_polls == POLL_LIMIT) begin m_pend = 0; m_to = 1; end
                end
            end
            if (fire) begin m_pend = 1; m_polls = 0; end
        end
    end

    task automatic check(input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            check(rst_req, m_pend, "rst_req");
            check(rst_timeout, m_to, "rst_timeout");
            check(link_change, m_chg, "link_change");
        end
    end

    task automatic run(input int n, input bit lu, input bit lb,
                       input int ms_every, input int us_every, input bit dn);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            link_up     = lu;
            loopback_on = lb;
            tick_ms     = (ms_every > 0) && (i % ms_every == 0);
            tick_us     = (us_every > 0) && (i % us_every == 0);
            rst_done    = dn;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rst_req, 1'b0, "reset rst_req");
        check(rst_timeout, 1'b0, "reset rst_timeout");
        check(link_change, 1'b0, "reset link_change");

        // R9 link edges, R3 ticks ignored while up
        tag = "R9";
        run(5, 1, 0, 1, 0, 0);
        run(3, 0, 0, 0, 0, 0);
        run(1, 1, 0, 0, 0, 0);
        run(1, 0, 0, 0, 0, 0);

        // R2 request after INTERVAL ticks; rst_done shown without tick_us is ignored (R5)
        tag = "R2";
        run(16, 0, 0, 2, 0, 1);
        check(rst_req, 1'b1, "request issued after interval");

        // R5 completion on a poll tick seeing done
        tag = "R5";
        run(7, 0, 0, 0, 3, 1);
        check(rst_req, 1'b0, "request cleared by done");

        // R4 / R8 timer restart at issue, hold while pending
        tag = "R8";
        run(14, 0, 0, 1, 0, 0);
        check(rst_req, 1'b1, "pending holds, no second request");
        tag = "R4";
        run(1, 0, 0, 0, 1, 1);
        run(12, 0, 0, 1, 0, 0);

        // R3 restart by one-cycle link blip
        tag = "R3";
        run(2, 0, 0, 0, 1, 1);
        run(4, 0, 0, 1, 0, 0);
        run(1, 1, 0, 1, 0, 0);
        run(5, 0, 0, 1, 0, 0);
        check(rst_req, 1'b0, "blip restarted the count");
        run(3, 0, 0, 1, 0, 0);

        // R10 loopback suppresses
        tag = "R10";
        run(2, 0, 0, 0, 1, 1);
        run(30, 0, 1, 1, 0, 0);
        check(rst_req, 1'b0, "no request in loopback");

        // R6 timeout after POLL_LIMIT failed polls
        tag = "R6";
        run(6, 0, 0, 1, 0, 0);
        run(POLL_LIMIT + 2, 0, 0, 0, 1, 0);
        check(rst_timeout, 1'b1, "timeout after poll limit");
        check(rst_req, 1'b0, "request abandoned");

        // R7 sticky across a later successful reset
        tag = "R7";
        run(8, 0, 0, 1, 0, 0);
        run(3, 0, 0, 0, 1, 1);
        check(rst_timeout, 1'b1, "timeout stays set");

        // R1 reset clears the flag
        tag = "R1";
        @(negedge clk); rst = 1'b1;
        run(2, 0, 0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rst_timeout, 1'b0, "reset clears timeout");
        check(rst_req, 1'b0, "reset clears request");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule